// File: doc/BRIEF.md
# Streaming YUV to RGBA Pixel Converter

This block turns a stream of 8-bit luma/chroma triples into packed 32-bit RGBA pixels. It accepts one pixel per clock and sends out one pixel per clock. The conversion uses fixed-point arithmetic with integer weights scaled by 256. Each chroma sample is first re-centred about 128. Each output channel is the luma scaled by 256 plus up to two weighted chroma terms. That sum is shifted right arithmetically by 8, and only the low byte is kept. Results that fall outside 0..255 therefore wrap around instead of saturating.

The datapath has three register stages: chroma centring, weighted products, and sum/shift/truncate. One valid bit travels alongside each stage. Both the input and the output side use a valid/ready handshake. When the output is holding a pixel that the consumer has not taken, every stage freezes together and the input stops accepting.

Top module: `yuv_rgba_pipe`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1 until a pixel has been accepted.
- R2: Byte 0 (bits 7:0) of `out_pixel` is the low 8 bits of floor((256*Y + 358*(V-128)) / 256).
- R3: Byte 1 (bits 15:8) is the low 8 bits of floor((256*Y - 88*(U-128) - 183*(V-128)) / 256).
- R4: Byte 2 (bits 23:16) is the low 8 bits of floor((256*Y + 454*(U-128)) / 256). Negative or over-range results wrap modulo 256 and are not clamped.
- R5: Byte 3 (bits 31:24) of every valid output pixel is 0.
- R6: A pixel accepted at clock edge k, with no stall afterwards, is valid on the outputs right after edge k+2. With `out_ready` held high, `in_ready` stays high and one pixel is accepted every cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and on the next cycle `out_valid` stays 1 with `out_pixel` unchanged.
- R8: Pixels leave in the order they were accepted, with none lost or duplicated, and at most 3 pixels are ever in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Converter can take a pixel this cycle |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_pixel | output | 32 | Packed pixel, R in byte 0 through alpha in byte 3 |

## Verification
A corrupted product or sum register in one channel would show up in exactly one byte of the pixel that leaves two cycles later. Comparing each byte separately therefore points to the faulty channel. A valid bit that is lost or stuck shows up at the output. The pixel count would come out short or extra, or the order would slip, and the failing pixel becomes visible within three cycles of its acceptance. A broken stall path shows up as well. The held pixel would change, or `in_ready` would stay high, in the very first cycle that `out_ready` is low.

// File: rtl/yuvpix_pkg.sv
package yuvpix_pkg;
  localparam int PIX_W      = 8;
  localparam int FRAC_W     = 8;
  localparam int ACC_W      = 20;
  localparam int CHROMA_MID = 128;
  localparam int NCH        = 3;

  typedef logic signed [PIX_W:0]   chroma_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  // Chroma weight per channel (0 = red, 1 = green, 2 = blue).
  function automatic int weight_u(input int ch);
    case (ch)
      1:       return -88;
      2:       return 454;
      default: return 0;
    endcase
  endfunction

  function automatic int weight_v(input int ch);
    case (ch)
      0:       return 358;
      1:       return -183;
      default: return 0;
    endcase
  endfunction

  // Re-centre an unsigned chroma sample about the mid code.
  function automatic chroma_t center(input logic [PIX_W-1:0] x);
    chroma_t ext;
    ext = $signed({1'b0, x});
    return ext - chroma_t'(CHROMA_MID);
  endfunction

  // Luma term: sample scaled by 2^FRAC_W, zero-extended into the accumulator.
  function automatic acc_t luma_term(input logic [PIX_W-1:0] y);
    acc_t t;
    t = '0;
    t[FRAC_W +: PIX_W] = y;
    return t;
  endfunction

  // Weighted chroma term.
  function automatic acc_t chroma_term(input int w, input chroma_t d);
    acc_t ww;
    acc_t dw;
    ww = acc_t'(w);
    dw = acc_t'(d);
    return ww * dw;
  endfunction

  // Arithmetic shift and wrap-around truncation to one byte.
  function automatic logic [PIX_W-1:0] wrap_byte(input acc_t s);
    acc_t sh;
    sh = s >>> FRAC_W;
    return sh[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/yuv_pipe_ctrl.sv
module yuv_pipe_ctrl #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             adv,
  output logic [DEPTH-1:0] stage_vld
);
  // Whole pipe moves together; it freezes only when the last stage is
  // holding a pixel the consumer refuses.
  assign adv = !stage_vld[DEPTH-1] || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stage_vld[0] <= 1'b0;
    else if (adv) stage_vld[0] <= in_valid;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_vld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stage_vld[s] <= 1'b0;
      else if (adv) stage_vld[s] <= stage_vld[s-1];
    end
  end
endmodule

// File: rtl/yuv_front.sv
module yuv_front
  import yuvpix_pkg::*;
#(
  parameter int PW = PIX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [PW-1:0] y_in,
  input  logic [PW-1:0] u_in,
  input  logic [PW-1:0] v_in,
  output logic [PW-1:0] y_q,
  output chroma_t       u_c,
  output chroma_t       v_c
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      u_c <= '0;
      v_c <= '0;
    end else if (adv) begin
      y_q <= y_in;
      u_c <= center(u_in);
      v_c <= center(v_in);
    end
  end
endmodule

// File: rtl/yuv_chan_mac.sv
module yuv_chan_mac
  import yuvpix_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int WU = 0,
  parameter int WV = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [PW-1:0] y_q,
  input  chroma_t       u_c,
  input  chroma_t       v_c,
  output logic [PW-1:0] chan_byte
);
  acc_t lt_q, pu_q, pv_q;
  acc_t sum_w;

  // Product stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_q <= '0;
      pu_q <= '0;
      pv_q <= '0;
    end else if (adv) begin
      lt_q <= luma_term(y_q);
      pu_q <= chroma_term(WU, u_c);
      pv_q <= chroma_term(WV, v_c);
    end
  end

  assign sum_w = lt_q + pu_q + pv_q;

  // Accumulate, shift, truncate stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chan_byte <= '0;
    else if (adv) chan_byte <= wrap_byte(sum_w);
  end
endmodule

// File: rtl/yuv_rgba_pipe.sv
module yuv_rgba_pipe
  import yuvpix_pkg::*;
#(
  parameter int PW    = PIX_W,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PW-1:0]   in_y,
  input  logic [PW-1:0]   in_u,
  input  logic [PW-1:0]   in_v,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [4*PW-1:0] out_pixel
);
  localparam int NBYTE = 4;

  logic             pipe_adv;
  logic [DEPTH-1:0] stage_vld;
  logic [PW-1:0]    y_q;
  chroma_t          u_c, v_c;
  logic [PW-1:0]    ch_byte [NCH];

  yuv_pipe_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .adv       (pipe_adv),
    .stage_vld (stage_vld)
  );

  yuv_front #(.PW(PW)) u_front (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pipe_adv),
    .y_in  (in_y),
    .u_in  (in_u),
    .v_in  (in_v),
    .y_q   (y_q),
    .u_c   (u_c),
    .v_c   (v_c)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    yuv_chan_mac #(
      .PW (PW),
      .WU (weight_u(c)),
      .WV (weight_v(c))
    ) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (pipe_adv),
      .y_q       (y_q),
      .u_c       (u_c),
      .v_c       (v_c),
      .chan_byte (ch_byte[c])
    );
    assign out_pixel[c*PW +: PW] = ch_byte[c];
  end

  for (genvar a = NCH; a < NBYTE; a++) begin : g_alpha
    assign out_pixel[a*PW +: PW] = '0;
  end

  assign in_ready  = pipe_adv;
  assign out_valid = stage_vld[DEPTH-1];
endmodule

// File: rtl/yuv_rgba_pipe_chk.sv
module yuv_rgba_pipe_chk #(
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4*PW-1:0] out_pixel
);
  logic       accept, emit, stall;
  logic [2:0] clean_sr;
  logic [3:0] in_flight;

  assign accept = in_valid && in_ready;
  assign emit   = out_valid && out_ready;
  assign stall  = out_valid && !out_ready;

  // Tracks acceptances not followed by any stall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     clean_sr <= '0;
    else if (stall) clean_sr <= '0;
    else            clean_sr <= {clean_sr[1:0], accept};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_flight <= '0;
    else        in_flight <= in_flight + 4'(accept) - 4'(emit);
  end

  assert_alpha_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pixel[4*PW-1 -: PW] == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> out_valid && $stable(out_pixel));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clean_sr[2] |-> out_valid);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= 4'd3);

  assert_no_phantom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_flight != 4'd0);
endmodule

bind yuv_rgba_pipe yuv_rgba_pipe_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pixel (out_pixel)
);

// File: tb/yuv_rgba_pipe_tb.sv
module yuv_rgba_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pixel;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  yuv_rgba_pipe u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_y      (in_y),
    .in_u      (in_u),
    .in_v      (in_v),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Floor division by 256, done with non-negative integer division only.
  function automatic int floor256(input int p);
    if (p >= 0) return p / 256;
    return -((-p + 255) / 256);
  endfunction

  function automatic logic [31:0] model(input logic [7:0] y, input logic [7:0] u, input logic [7:0] v);
    int du, dv, r, g, b;
    du = int'(u) - 128;
    dv = int'(v) - 128;
    r  = int'(y) + floor256(358 * dv);
    g  = int'(y) + floor256(-88 * du - 183 * dv);
    b  = int'(y) + floor256(454 * du);
    return {8'h00, 8'(b & 255), 8'(g & 255), 8'(r & 255)};
  endfunction

  function automatic logic [23:0] gen(input int seed, input int idx);
    if (seed == 0) begin
      case (idx % 8)
        0: return {8'd0,   8'd128, 8'd128};
        1: return {8'd255, 8'd128, 8'd128};
        2: return {8'd0,   8'd0,   8'd0};
        3: return {8'd255, 8'd255, 8'd255};
        4: return {8'd0,   8'd255, 8'd0};
        5: return {8'd255, 8'd0,   8'd255};
        6: return {8'd128, 8'd0,   8'd0};
        default: return {8'd16, 8'd240, 8'd240};
      endcase
    end
    return {8'((idx * 73 + seed * 29 + 5) % 256),
            8'((idx * 151 + seed * 13) % 256),
            8'((idx * 199 + seed * 71 + 128) % 256)};
  endfunction

  function automatic bit ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return (cyc >= 8) && (((cyc * 5) % 7) != 0);
      default: return (cyc % 3) != 0;
    endcase
  endfunction

  task automatic check_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic check_latency();
    logic [23:0] p;
    logic [31:0] exp;
    p = gen(7, 3);
    exp = model(p[23:16], p[15:8], p[7:0]);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    {in_y, in_u, in_v} = p;
    @(negedge clk);              // edge k has accepted the pixel
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 not valid after edge k", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 not valid after edge k+1", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid after edge k+2", 32'(out_valid), 32'd1);
    chk(out_pixel == exp, "R6 pixel value at latency", out_pixel, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 single pixel leaves once", 32'(out_valid), 32'd0);
  endtask

  task automatic run_stream(input int n, input int mode, input int seed);
    int tx = 0;
    int rx = 0;
    int cyc = 0;
    bit prev_stall = 1'b0;
    logic [31:0] prev_px = '0;
    logic [23:0] p;
    logic [31:0] exp;
    while (rx < n && cyc < 4000) begin
      @(negedge clk);
      out_ready = ready_pat(mode, cyc);
      in_valid  = (tx < n);
      {in_y, in_u, in_v} = gen(seed, tx);
      #1;
      if (prev_stall)
        chk(out_valid && out_pixel == prev_px, "R7 held pixel stable", out_pixel, prev_px);
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R7 input blocked on stall", 32'(in_ready), 32'd0);
      if (mode == 0)
        chk(in_ready == 1'b1, "R6 full throughput", 32'(in_ready), 32'd1);
      if (out_valid && out_ready) begin
        p   = gen(seed, rx);
        exp = model(p[23:16], p[15:8], p[7:0]);
        chk(out_pixel[7:0]   == exp[7:0],   "R2 red byte",   out_pixel, exp);
        chk(out_pixel[15:8]  == exp[15:8],  "R3 green byte", out_pixel, exp);
        chk(out_pixel[23:16] == exp[23:16], "R4 blue byte",  out_pixel, exp);
        chk(out_pixel[31:24] == 8'h00,      "R5 alpha byte", out_pixel, exp);
        rx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_px    = out_pixel;
      if (in_valid && in_ready) tx++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    chk(rx == n, "R8 all pixels delivered", 32'(rx), 32'(n));
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 no extra pixels", 32'(out_valid), 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    check_reset();
    check_latency();
    run_stream(16, 0, 0);   // wrap-around corners, R2 R3 R4
    run_stream(40, 0, 3);
    run_stream(40, 1, 5);
    run_stream(40, 2, 9);   // long initial stall fills the pipe
    run_stream(40, 3, 11);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule